// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

The sequencer produces the strobe timing and the address and data phasing of a multiplexed 8-bit external memory bus. It runs from the oscillator clock. A machine cycle is twelve clock periods, numbered 0 to 11. A shared pin set carries the low address byte and then the data byte. A separate port carries the high address byte. The block drives an address latch strobe, a code read strobe and separate data read and data write strobes, all with fixed positions inside the machine cycle.

A requester offers one transfer at a time: a code fetch, a data read or a data write. It supplies an address, write data and a flag that picks a 16-bit or an 8-bit data address. The block takes the transfer only at a machine-cycle boundary. In machine cycles with no request, the latch and code strobes keep running at their normal rate over the last address. During a data cycle, one latch pulse and both code-strobe pulses are left out. A configuration bit written through a small register port holds the latch strobe high during code and idle cycles, which reduces emissions.

Top module: `xbus_seq`

## Requirements
- R1: A request is taken only at the clock edge that ends a period where `req_ready` is high, which is period 11. The kind is decoded from `req_kind` as follows: bit 1 low means a code fetch, `2'b10` means a data read and `2'b11` means a data write. `busy` is high from period 0 through period 5 of a code cycle and through period 10 of a data cycle. It is low in idle cycles.
- R2: In code and idle cycles, `ale` is high in periods 0, 1, 6 and 7, and `psen_n` is low in periods 3, 4, 5, 9, 10 and 11.
- R3: In data cycles, `ale` is high only in periods 0 and 1, so the second pulse is skipped. `psen_n` stays high for the whole cycle.
- R4: The low address byte is on `ad_out` with `ad_oe` high in each period where the latch strobe is scheduled. `ad_oe` is low again before `psen_n` or `rd_n` falls.
- R5: For a data read, `rd_n` is low in periods 5 to 10. That is 6 periods long, and it falls 3 periods after `ale` falls. `ad_in` is captured at the end of period 10. For a code fetch, `ad_in` is captured at the end of period 5. `rd_data` holds its value until the next capture.
- R6: For a data write, `wr_n` is low in periods 5 to 10. The write byte is on `ad_out` with `ad_oe` high from period 4 to period 11, which is one period before `wr_n` falls and one period after it rises.
- R7: The high port `a_hi` carries the upper address byte for code fetches and for data transfers with `req_wide` high. For data transfers with `req_wide` low, it carries `p2_latch` as sampled when the request is taken. Idle cycles keep the previous high and low address bytes.
- R8: A write with `sfr_addr` equal to 0x8E loads bit 0 of `sfr_wdata` into the suppression bit. Writes to any other address leave the bit unchanged. While the bit is set, `ale` is held high through code and idle cycles. Data cycles keep their single pulse in periods 0 and 1.
- R9: While `rst_n` is low, the outputs are as follows: `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe`, `busy`, `rd_data` and `a_hi` are 0, and `req_ready` is 1. The suppression bit is cleared. The first machine cycle begins at the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period per bus period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | A transfer is offered |
| req_kind | input | 2 | Transfer kind: 0x code, 10 data read, 11 data write |
| req_addr | input | 16 | Transfer address |
| req_wide | input | 1 | Data transfer uses the full 16-bit address |
| req_wdata | input | 8 | Byte to write |
| p2_latch | input | 8 | High port latch contents, used for 8-bit data addresses |
| req_ready | output | 1 | High in the last period of a machine cycle |
| busy | output | 1 | Accepted transfer not yet finished |
| rd_data | output | 8 | Last fetched code byte or read data byte |
| sfr_we | input | 1 | Configuration register write strobe |
| sfr_addr | input | 8 | Configuration register address |
| sfr_wdata | input | 8 | Configuration register write data |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed low address / write data byte |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 8 | Multiplexed bus input byte |
| a_hi | output | 8 | High address port |

## Verification
Every strobe is decoded directly from the period counter and the latched cycle kind. If the counter slips or the kind is latched wrongly, a pulse lands in the wrong period or goes missing in the very next period, and the bench compares every output in every period. A wrong address or high-byte register shows up at the first latch-strobe period, which is period 0 of the cycle that follows. A wrong capture point shows up in `rd_data` by period 11 of the same machine cycle. A suppression bit that was set when it should not be, or the reverse, makes `ale` differ within one period.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

  typedef enum logic [2:0] {
    CYC_HALT,
    CYC_IDLE,
    CYC_CODE,
    CYC_READ,
    CYC_WRITE
  } cyc_e;

  // machine cycle geometry, in oscillator periods
  localparam int unsigned MC_LEN   = 12;
  localparam int unsigned ALE_LEN  = 2;
  localparam int unsigned PSEN_OFS = 3;
  localparam int unsigned PSEN_LEN = 3;
  localparam int unsigned DSTB_OFS = 5;
  localparam int unsigned DSTB_LEN = 6;

endpackage

// File: rtl/xbus_seq_phase.sv
module xbus_seq_phase #(
  parameter int unsigned MC_LEN = 12,
  parameter int unsigned PW     = $clog2(MC_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          last
);
  localparam logic [PW-1:0] P_LAST = PW'(MC_LEN - 1);

  logic [PW-1:0] phase_d;
  logic [PW-1:0] phase_q;

  assign last  = (phase_q == P_LAST);
  assign phase = phase_q;

  always_comb begin
    phase_d = last ? '0 : phase_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= P_LAST;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/xbus_seq_ctrl.sv
module xbus_seq_ctrl
  import xbus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SFR_AW   = 8,
  parameter logic [SFR_AW-1:0] AUX_ADDR = 8'h8E,
  parameter int unsigned PW       = 4,
  parameter int unsigned HI_W     = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     phase,
  input  logic              last,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [HI_W-1:0]   p2_latch,
  input  logic              sfr_we,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output cyc_e              cyc,
  output logic [DATA_W-1:0] addr_lo,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] wdata,
  output logic              ale_off,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [PW-1:0] P_CODE_CAP = PW'(PSEN_OFS + PSEN_LEN - 1);
  localparam logic [PW-1:0] P_READ_CAP = PW'(DSTB_OFS + DSTB_LEN - 1);

  cyc_e              cyc_d, cyc_q;
  logic [DATA_W-1:0] lo_d, lo_q;
  logic [HI_W-1:0]   hi_d, hi_q;
  logic [DATA_W-1:0] wd_d, wd_q;
  logic              off_d, off_q;
  logic [DATA_W-1:0] rdat_d, rdat_q;
  logic              take;
  logic              cap_en;

  assign take   = last && req_valid;
  assign cap_en = ((cyc_q == CYC_CODE) && (phase == P_CODE_CAP)) ||
                  ((cyc_q == CYC_READ) && (phase == P_READ_CAP));

  always_comb begin
    cyc_d = cyc_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    wd_d  = wd_q;
    if (last) begin
      cyc_d = CYC_IDLE;
      if (take) begin
        if (!req_kind[1])     cyc_d = CYC_CODE;
        else if (req_kind[0]) cyc_d = CYC_WRITE;
        else                  cyc_d = CYC_READ;
        lo_d = req_addr[DATA_W-1:0];
        hi_d = (!req_kind[1] || req_wide) ? req_addr[ADDR_W-1:DATA_W] : p2_latch;
        wd_d = req_wdata;
      end
    end
  end

  always_comb begin
    off_d = off_q;
    if (sfr_we && (sfr_addr == AUX_ADDR)) off_d = sfr_wdata[0];
  end

  always_comb begin
    rdat_d = cap_en ? ad_in : rdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= CYC_HALT;
      lo_q   <= '0;
      hi_q   <= '0;
      wd_q   <= '0;
      off_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      wd_q   <= wd_d;
      off_q  <= off_d;
      rdat_q <= rdat_d;
    end
  end

  assign cyc     = cyc_q;
  assign addr_lo = lo_q;
  assign addr_hi = hi_q;
  assign wdata   = wd_q;
  assign ale_off = off_q;
  assign rd_data = rdat_q;
endmodule

// File: rtl/xbus_seq_strobe.sv
module xbus_seq_strobe
  import xbus_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PW     = 4
) (
  input  logic [PW-1:0]     phase,
  input  cyc_e              cyc,
  input  logic              ale_off,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ad_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              busy
);
  localparam logic [PW-1:0] P_HALF    = PW'(MC_LEN / 2);
  localparam logic [PW-1:0] P_ALE     = PW'(ALE_LEN);
  localparam logic [PW-1:0] P_PS_ON   = PW'(PSEN_OFS);
  localparam logic [PW-1:0] P_PS_OFF  = PW'(PSEN_OFS + PSEN_LEN);
  localparam logic [PW-1:0] P_DS_ON   = PW'(DSTB_OFS);
  localparam logic [PW-1:0] P_DS_OFF  = PW'(DSTB_OFS + DSTB_LEN);
  localparam logic [PW-1:0] P_WD_ON   = PW'(DSTB_OFS - 1);
  localparam logic [PW-1:0] P_WD_LAST = PW'(DSTB_OFS + DSTB_LEN);

  logic [PW-1:0] sub;
  logic          is_data;
  logic          running;
  logic          addr_win;
  logic          dstb_win;
  logic          wd_win;

  always_comb begin
    sub      = (phase >= P_HALF) ? phase - P_HALF : phase;
    is_data  = (cyc == CYC_READ) || (cyc == CYC_WRITE);
    running  = (cyc != CYC_HALT);
    dstb_win = (phase >= P_DS_ON) && (phase < P_DS_OFF);
    wd_win   = (cyc == CYC_WRITE) && (phase >= P_WD_ON) && (phase <= P_WD_LAST);
    addr_win = is_data ? (phase < P_ALE) : (running && (sub < P_ALE));
  end

  always_comb begin
    if (!running)     ale = 1'b0;
    else if (is_data) ale = (phase < P_ALE);
    else              ale = ale_off || (sub < P_ALE);
  end

  always_comb begin
    psen_n = !(running && !is_data && (sub >= P_PS_ON) && (sub < P_PS_OFF));
    rd_n   = !((cyc == CYC_READ)  && dstb_win);
    wr_n   = !((cyc == CYC_WRITE) && dstb_win);
    ad_oe  = addr_win || wd_win;
    ad_out = wd_win ? wdata : addr_lo;
  end

  always_comb begin
    unique case (cyc)
      CYC_CODE:            busy = (phase < P_PS_OFF);
      CYC_READ, CYC_WRITE: busy = (phase < P_DS_OFF);
      default:             busy = 1'b0;
    endcase
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SFR_AW   = 8,
  parameter logic [SFR_AW-1:0] AUX_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ADDR_W-DATA_W-1:0] p2_latch,
  output logic              req_ready,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sfr_we,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-DATA_W-1:0] a_hi
);
  localparam int unsigned PW   = $clog2(MC_LEN);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [PW-1:0]     phase;
  logic              last;
  cyc_e              cyc;
  logic [DATA_W-1:0] addr_lo;
  logic [DATA_W-1:0] wdata;
  logic              ale_off;

  xbus_seq_phase #(.MC_LEN(MC_LEN), .PW(PW)) phase_i (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase),
    .last  (last)
  );

  xbus_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SFR_AW(SFR_AW),
    .AUX_ADDR(AUX_ADDR), .PW(PW), .HI_W(HI_W)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .last      (last),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wide  (req_wide),
    .req_wdata (req_wdata),
    .p2_latch  (p2_latch),
    .sfr_we    (sfr_we),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .ad_in     (ad_in),
    .cyc       (cyc),
    .addr_lo   (addr_lo),
    .addr_hi   (a_hi),
    .wdata     (wdata),
    .ale_off   (ale_off),
    .rd_data   (rd_data)
  );

  xbus_seq_strobe #(.DATA_W(DATA_W), .PW(PW)) strobe_i (
    .phase   (phase),
    .cyc     (cyc),
    .ale_off (ale_off),
    .addr_lo (addr_lo),
    .wdata   (wdata),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .ad_oe   (ad_oe),
    .ad_out  (ad_out),
    .busy    (busy)
  );

  assign req_ready = last;

  // R1
  accept_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_ready));

  // R2
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ale) && !sfr_we) |=> ale);

  // R3
  data_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (psen_n && !ale));

  // R4
  psen_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !ad_oe);

  // R5
  ale_to_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (!$past(ale, 3) && $past(ale, 4)));

  // R6
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(ad_oe));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);
endmodule

// File: tb/xbus_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_seq_tb_top;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_kind;
  logic [15:0] req_addr;
  logic       req_wide;
  logic [7:0] req_wdata;
  logic [7:0] p2_latch;
  logic       req_ready;
  logic       busy;
  logic [7:0] rd_data;
  logic       sfr_we;
  logic [7:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic       ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0] ad_out;
  logic [7:0] ad_in;
  logic [7:0] a_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_lo, m_hi, m_rd;
  bit         m_off;

  xbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wide(req_wide), .req_wdata(req_wdata),
    .p2_latch(p2_latch), .req_ready(req_ready), .busy(busy), .rd_data(rd_data),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] code_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] data_byte(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h33;
  endfunction

  // kind: 0 idle, 1 code, 2 read, 3 write
  function automatic bit e_ale(input int k, input int p, input bit off);
    if (k >= 2) return p < 2;
    return off || ((p % 6) < 2);
  endfunction

  function automatic bit e_psen_n(input int k, input int p);
    if (k >= 2) return 1'b1;
    return !((p % 6) >= 3);
  endfunction

  function automatic bit e_oe(input int k, input int p);
    if (k >= 2) return (p < 2) || (k == 3 && p >= 4);
    return (p % 6) < 2;
  endfunction

  function automatic bit e_busy(input int k, input int p);
    if (k == 1) return p <= 5;
    if (k >= 2) return p <= 10;
    return 1'b0;
  endfunction

  task automatic do_cycle(input int k, input logic [15:0] a, input bit wide,
                          input logic [7:0] wd, input logic [7:0] p2,
                          input bit sw, input logic [7:0] sa, input logic [7:0] sd);
    string rq;
    chk(req_ready == 1'b1, "R1", "req_ready at boundary", req_ready, 1);
    req_valid = (k != 0);
    req_kind  = (k == 1) ? 2'b00 : (k == 2) ? 2'b10 : 2'b11;
    req_addr  = a;
    req_wide  = wide;
    req_wdata = wd;
    p2_latch  = p2;
    ad_in     = (k == 1) ? code_byte(a) : (k == 2) ? data_byte(a) : 8'($urandom);
    sfr_we    = sw;
    sfr_addr  = sa;
    sfr_wdata = sd;
    if (sw && sa == 8'h8E) m_off = sd[0];
    if (k != 0) begin
      m_lo = a[7:0];
      m_hi = (k == 1 || wide) ? a[15:8] : p2;
    end
    rq = (k >= 2) ? "R3" : "R2";
    @(posedge clk);
    for (int p = 0; p < 12; p++) begin
      @(negedge clk);
      if (p == 0) begin
        req_valid = 1'b0;
        sfr_we    = 1'b0;
        p2_latch  = 8'($urandom);
        req_addr  = 16'($urandom);
        req_wdata = 8'($urandom);
      end
      chk(ale == e_ale(k, p, m_off), (m_off && k < 2) ? "R8" : rq, "ale", ale, e_ale(k, p, m_off));
      chk(psen_n == e_psen_n(k, p), rq, "psen_n", psen_n, e_psen_n(k, p));
      chk(rd_n == !(k == 2 && p >= 5 && p <= 10), "R5", "rd_n", rd_n, !(k == 2 && p >= 5 && p <= 10));
      chk(wr_n == !(k == 3 && p >= 5 && p <= 10), "R6", "wr_n", wr_n, !(k == 3 && p >= 5 && p <= 10));
      chk(ad_oe == e_oe(k, p), "R4", "ad_oe", ad_oe, e_oe(k, p));
      if (e_oe(k, p)) begin
        if (k == 3 && p >= 4) chk(ad_out == wd, "R6", "write byte", ad_out, wd);
        else                  chk(ad_out == m_lo, "R4", "low address", ad_out, m_lo);
      end
      chk(a_hi == m_hi, "R7", "high port", a_hi, m_hi);
      chk(busy == e_busy(k, p), "R1", "busy", busy, e_busy(k, p));
      chk(req_ready == (p == 11), "R1", "req_ready", req_ready, (p == 11));
      if (p == 11) begin
        if (k == 1) m_rd = code_byte(a);
        if (k == 2) m_rd = data_byte(a);
        chk(rd_data == m_rd, "R5", "rd_data", rd_data, m_rd);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0;
    req_wide = 1'b0; req_wdata = '0; p2_latch = '0; sfr_we = 1'b0;
    sfr_addr = '0; sfr_wdata = '0; ad_in = '0;
    m_lo = '0; m_hi = '0; m_rd = '0; m_off = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(ale == 1'b0, "R9", "ale in reset", ale, 0);
    chk(psen_n == 1'b1, "R9", "psen_n in reset", psen_n, 1);
    chk(rd_n == 1'b1 && wr_n == 1'b1, "R9", "rd_n/wr_n in reset", {rd_n, wr_n}, 3);
    chk(ad_oe == 1'b0, "R9", "ad_oe in reset", ad_oe, 0);
    chk(busy == 1'b0, "R9", "busy in reset", busy, 0);
    chk(req_ready == 1'b1, "R9", "req_ready in reset", req_ready, 1);
    chk(rd_data == 8'h00 && a_hi == 8'h00, "R9", "data/high in reset", {rd_data, a_hi}, 0);
    rst_n = 1'b1;

    // directed corners
    do_cycle(1, 16'h1234, 0, 8'h00, 8'h00, 0, 8'h00, 8'h00);   // R2 code
    do_cycle(0, 16'h0000, 0, 8'h00, 8'hEE, 0, 8'h00, 8'h00);   // R2 idle holds address
    do_cycle(2, 16'hABCD, 1, 8'h00, 8'h11, 0, 8'h00, 8'h00);   // R5 wide read
    do_cycle(2, 16'h55C3, 0, 8'h00, 8'h77, 0, 8'h00, 8'h00);   // R7 narrow read
    do_cycle(3, 16'h8001, 1, 8'hA5, 8'h22, 0, 8'h00, 8'h00);   // R6 wide write
    do_cycle(3, 16'h7F10, 0, 8'h3C, 8'h99, 0, 8'h00, 8'h00);   // R6/R7 narrow write
    do_cycle(1, 16'h0F0F, 0, 8'h00, 8'h00, 1, 8'h8F, 8'hFF);   // R8 other address ignored
    do_cycle(1, 16'h2222, 0, 8'h00, 8'h00, 1, 8'h8E, 8'h01);   // R8 suppression on
    do_cycle(2, 16'h3344, 1, 8'h00, 8'h00, 0, 8'h00, 8'h00);   // R8 data pulse kept
    do_cycle(0, 16'h0000, 0, 8'h00, 8'h00, 0, 8'h00, 8'h00);   // R8 idle held high
    do_cycle(1, 16'h4455, 0, 8'h00, 8'h00, 1, 8'h8E, 8'hFE);   // R8 suppression off
    do_cycle(3, 16'hFFFF, 1, 8'h00, 8'h00, 0, 8'h00, 8'h00);
    do_cycle(2, 16'h0000, 1, 8'h00, 8'h00, 0, 8'h00, 8'h00);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int k;
      bit sw;
      logic [7:0] sa;
      k  = int'($urandom_range(0, 3));
      sw = ($urandom_range(0, 7) == 0);
      sa = ($urandom_range(0, 1) == 1) ? 8'h8E : 8'($urandom);
      do_cycle(k, 16'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
               sw, sa, 8'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule